// File: doc/BRIEF.md
# Threshold-Driven FIFO Service Requester

This block sits between a bus host and a serial shift engine. It holds one transmit queue and one receive queue, each 24 words deep. The host fills the transmit queue and the engine drains it. Each transmit word carries one extra tag bit, taken from a control input at the moment of the write. The tag tells the engine whether the word is payload or a control word, such as a run of dummy cycles. The engine fills the receive queue and the host drains it.

Two threshold settings decide when the host is asked to act. A transmit request stands when the transmit fill level is strictly below its threshold. A receive request stands when the receive fill level is strictly above its threshold. Each direction has its own interrupt enable and its own DMA enable.

Four copies of a two-state request machine carry the requests, with states `REQ_IDLE` and `REQ_PEND`:
- The transition `REQ_IDLE` to `REQ_PEND` ("arm") happens when the channel is enabled and its threshold condition holds.
- The transition `REQ_PEND` to `REQ_IDLE` happens on "disable", when the enable is withdrawn.
- For an interrupt channel, `REQ_PEND` to `REQ_IDLE` ("clear") happens on a clear strobe, but only if the condition is false in that cycle.
- For a DMA channel, `REQ_PEND` to `REQ_IDLE` ("ack") happens on the acknowledge, unconditionally.

The block also reports the DMA burst sizes that follow from the thresholds. A flush command empties both queues at once.

Top module: `svc_fifo_pair`

## Requirements
- R1: After reset, both levels are 0, all four requests are low, and both sticky flags are low.
- R2: The TX queue returns words in write order. Each word comes back with the tag sampled from `tx_tag_ctl` in its write cycle (0 = plain data, 1 = control word). `tx_level` counts the stored words and never exceeds 24. An empty TX queue presents data 0 and tag 0.
- R3: A TX write while `tx_level` is 24 is dropped. It sets `tx_overflow`, which stays high until flush or reset.
- R4: A host read of an empty RX queue presents `rx_rd_data` = 0 and sets `rx_underflow`, which is sticky until flush or reset. An engine push into a full RX queue is dropped. Otherwise the RX queue is first-in first-out.
- R5: While `tx_irq_en` is set, `tx_irq` rises one cycle after a cycle with `tx_level < tx_thresh`. It stays high after the condition ends until it is cleared.
- R6: While `rx_irq_en` is set, `rx_irq` rises one cycle after a cycle with `rx_level > rx_thresh`. It then stays pending in the same way.
- R7: An interrupt clear strobe in a cycle where its condition still holds has no effect. In a cycle where the condition is false, the interrupt is low in the next cycle.
- R8: A DMA request rises one cycle after its enabled condition holds. It is low in the cycle after an acknowledge. If the condition still holds, it rises again one cycle later.
- R9: `rx_burst_len` equals `rx_thresh + 1`. `tx_burst_len` equals `24 - tx_thresh`, for `tx_thresh` from 0 to 24.
- R10: A flush empties both queues, sets both levels to 0, and clears both sticky flags in the next cycle. It overrides any push or pop in the same cycle.
- R11: Clearing an enable forces its request low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty both queues, clear sticky flags |
| tx_thresh | input | 5 | TX request threshold |
| rx_thresh | input | 5 | RX request threshold |
| tx_irq_en | input | 1 | Enable TX interrupt request |
| rx_irq_en | input | 1 | Enable RX interrupt request |
| tx_dma_en | input | 1 | Enable TX DMA request |
| rx_dma_en | input | 1 | Enable RX DMA request |
| tx_irq_clr | input | 1 | TX interrupt clear strobe |
| rx_irq_clr | input | 1 | RX interrupt clear strobe |
| tx_dma_ack | input | 1 | TX DMA acknowledge |
| rx_dma_ack | input | 1 | RX DMA acknowledge |
| tx_wr_en | input | 1 | Host write into TX queue |
| tx_wr_data | input | 32 | Host write data |
| tx_tag_ctl | input | 1 | Tag stored with the TX write |
| tx_rd_en | input | 1 | Engine pop from TX queue |
| tx_rd_data | output | 32 | Head TX word |
| tx_rd_tag | output | 1 | Tag of the head TX word |
| rx_wr_en | input | 1 | Engine push into RX queue |
| rx_wr_data | input | 32 | Engine push data |
| rx_rd_en | input | 1 | Host pop from RX queue |
| rx_rd_data | output | 32 | Head RX word, 0 when empty |
| tx_level | output | 5 | TX fill level |
| rx_level | output | 5 | RX fill level |
| tx_irq | output | 1 | TX interrupt request |
| rx_irq | output | 1 | RX interrupt request |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |
| tx_burst_len | output | 6 | Words per DMA write burst |
| rx_burst_len | output | 6 | Words per DMA read burst |
| tx_overflow | output | 1 | Sticky TX write-when-full flag |
| rx_underflow | output | 1 | Sticky RX read-when-empty flag |

## Verification
The critical same-cycle collisions are these:
- An interrupt clear strobe landing in a cycle where the threshold condition is still true.
- A flush landing together with a write into a full queue, or with a read from an empty one.

The bench drives both collisions on purpose. It issues an RX clear while the level is still above threshold, and it issues a flush alongside a TX write. A long random phase then throws all strobes at once.

A behavioural queue model, stepped on every clock, decides the expected outcome. It expects the pending interrupt to survive the blocked clear. It expects the flush to win over the push, leaving zero levels and clear flags.

// File: rtl/svc_fifo_pkg.sv
package svc_fifo_pkg;
    typedef enum logic [0:0] {
        REQ_IDLE = 1'b0,
        REQ_PEND = 1'b1
    } req_state_e;
endpackage

// File: rtl/svc_sync_fifo.sv
module svc_sync_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 24,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    output logic [LVL_W-1:0] level
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] cnt_q, cnt_d;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Acceptance is judged on the level before this cycle's traffic.
    assign push_ok = push && !flush && (cnt_q != LVL_W'(DEPTH));
    assign pop_ok  = pop  && !flush && (cnt_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (push_ok && !pop_ok)
            cnt_d = cnt_q + 1'b1;
        else if (pop_ok && !push_ok)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    assign pop_data = (cnt_q == '0) ? '0 : mem[rd_ptr];
    assign level    = cnt_q;
endmodule

// File: rtl/svc_req_fsm.sv
module svc_req_fsm
    import svc_fifo_pkg::*;
#(
    // 1: a clear is ignored while the condition holds (interrupt style)
    // 0: the acknowledge always retires the request (DMA style)
    parameter bit HOLD_ON_COND = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cond,
    input  logic clear,
    output logic req
);
    req_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: if (enable && cond) state_d = REQ_PEND;          // arm
            REQ_PEND: begin
                if (!enable)
                    state_d = REQ_IDLE;                                 // disable
                else if (clear && !(HOLD_ON_COND && cond))
                    state_d = REQ_IDLE;                                 // clear / ack
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req = (state_q == REQ_PEND);
    end
endmodule

// File: rtl/svc_fifo_pair.sv
module svc_fifo_pair #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 24,
    localparam int LVL_W   = $clog2(DEPTH + 1),
    localparam int BURST_W = LVL_W + 1,
    localparam int NUM_REQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [LVL_W-1:0]   tx_thresh,
    input  logic [LVL_W-1:0]   rx_thresh,
    input  logic               tx_irq_en,
    input  logic               rx_irq_en,
    input  logic               tx_dma_en,
    input  logic               rx_dma_en,
    input  logic               tx_irq_clr,
    input  logic               rx_irq_clr,
    input  logic               tx_dma_ack,
    input  logic               rx_dma_ack,
    input  logic               tx_wr_en,
    input  logic [DATA_W-1:0]  tx_wr_data,
    input  logic               tx_tag_ctl,
    input  logic               tx_rd_en,
    output logic [DATA_W-1:0]  tx_rd_data,
    output logic               tx_rd_tag,
    input  logic               rx_wr_en,
    input  logic [DATA_W-1:0]  rx_wr_data,
    input  logic               rx_rd_en,
    output logic [DATA_W-1:0]  rx_rd_data,
    output logic [LVL_W-1:0]   tx_level,
    output logic [LVL_W-1:0]   rx_level,
    output logic               tx_irq,
    output logic               rx_irq,
    output logic               tx_dma_req,
    output logic               rx_dma_req,
    output logic [BURST_W-1:0] tx_burst_len,
    output logic [BURST_W-1:0] rx_burst_len,
    output logic               tx_overflow,
    output logic               rx_underflow
);
    logic [DATA_W:0]      tx_head;
    logic                 tx_below, rx_above;
    logic [NUM_REQ-1:0]   ch_en, ch_cond, ch_clr, ch_req;
    logic                 tx_ovf_q, rx_unf_q;

    svc_sync_fifo #(.W(DATA_W + 1), .DEPTH(DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (tx_wr_en),
        .push_data ({tx_tag_ctl, tx_wr_data}),
        .pop       (tx_rd_en),
        .pop_data  (tx_head),
        .level     (tx_level)
    );

    svc_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (rx_wr_en),
        .push_data (rx_wr_data),
        .pop       (rx_rd_en),
        .pop_data  (rx_rd_data),
        .level     (rx_level)
    );

    assign tx_rd_data = tx_head[DATA_W-1:0];
    assign tx_rd_tag  = tx_head[DATA_W];

    // Sticky error flags; flush takes priority over a same-cycle error.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            tx_ovf_q <= 1'b0;
            rx_unf_q <= 1'b0;
        end else begin
            if (tx_wr_en && tx_level == LVL_W'(DEPTH)) tx_ovf_q <= 1'b1;
            if (rx_rd_en && rx_level == '0)            rx_unf_q <= 1'b1;
        end
    end
    assign tx_overflow  = tx_ovf_q;
    assign rx_underflow = rx_unf_q;

    assign tx_below = (tx_level < tx_thresh);
    assign rx_above = (rx_level > rx_thresh);

    // Channel order: 0 TX irq, 1 RX irq, 2 TX dma, 3 RX dma
    assign ch_en   = {rx_dma_en,  tx_dma_en,  rx_irq_en,  tx_irq_en};
    assign ch_cond = {rx_above,   tx_below,   rx_above,   tx_below};
    assign ch_clr  = {rx_dma_ack, tx_dma_ack, rx_irq_clr, tx_irq_clr};

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        svc_req_fsm #(.HOLD_ON_COND(g < 2)) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (ch_en[g]),
            .cond   (ch_cond[g]),
            .clear  (ch_clr[g]),
            .req    (ch_req[g])
        );
    end

    assign tx_irq     = ch_req[0];
    assign rx_irq     = ch_req[1];
    assign tx_dma_req = ch_req[2];
    assign rx_dma_req = ch_req[3];

    assign tx_burst_len = BURST_W'(DEPTH) - BURST_W'(tx_thresh);
    assign rx_burst_len = BURST_W'(rx_thresh) + 1'b1;
endmodule

// File: rtl/svc_fifo_pair_chk.sv
module svc_fifo_pair_chk #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 24,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic [LVL_W-1:0]  tx_thresh,
    input logic [LVL_W-1:0]  rx_thresh,
    input logic              tx_irq_en,
    input logic              rx_irq_en,
    input logic              tx_dma_en,
    input logic              tx_wr_en,
    input logic              tx_rd_en,
    input logic              tx_dma_ack,
    input logic [LVL_W-1:0]  tx_level,
    input logic [LVL_W-1:0]  rx_level,
    input logic [DATA_W-1:0] rx_rd_data,
    input logic              tx_irq,
    input logic              rx_irq,
    input logic              tx_dma_req,
    input logic              tx_overflow,
    input logic              rx_underflow
);
    assert_level_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == LVL_W'(DEPTH) && tx_wr_en && !tx_rd_en && !flush)
        |=> (tx_level == LVL_W'(DEPTH) && tx_overflow));

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overflow && !flush) |=> tx_overflow);

    assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> (rx_rd_data == '0));

    assert_tx_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq_en && tx_level < tx_thresh) |=> tx_irq);

    assert_rx_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq_en && rx_level > rx_thresh) |=> rx_irq);

    assert_clr_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && tx_irq_en && tx_level < tx_thresh) |=> tx_irq);

    assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dma_req && tx_dma_ack) |=> !tx_dma_req);

    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_level == '0 && rx_level == '0 && !tx_overflow && !rx_underflow));

    assert_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_dma_en |=> !tx_dma_req);
endmodule

bind svc_fifo_pair svc_fifo_pair_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .tx_thresh    (tx_thresh),
    .rx_thresh    (rx_thresh),
    .tx_irq_en    (tx_irq_en),
    .rx_irq_en    (rx_irq_en),
    .tx_dma_en    (tx_dma_en),
    .tx_wr_en     (tx_wr_en),
    .tx_rd_en     (tx_rd_en),
    .tx_dma_ack   (tx_dma_ack),
    .tx_level     (tx_level),
    .rx_level     (rx_level),
    .rx_rd_data   (rx_rd_data),
    .tx_irq       (tx_irq),
    .rx_irq       (rx_irq),
    .tx_dma_req   (tx_dma_req),
    .tx_overflow  (tx_overflow),
    .rx_underflow (rx_underflow)
);

// File: tb/test_svc_fifo_pair.sv
module test_svc_fifo_pair;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 24;
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int BW     = LVL_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 0;
    logic [LVL_W-1:0] tx_thresh = 4, rx_thresh = 2;
    logic tx_irq_en = 1, rx_irq_en = 1, tx_dma_en = 1, rx_dma_en = 1;
    logic tx_irq_clr = 0, rx_irq_clr = 0, tx_dma_ack = 0, rx_dma_ack = 0;
    logic tx_wr_en = 0, tx_tag_ctl = 0, tx_rd_en = 0, rx_wr_en = 0, rx_rd_en = 0;
    logic [DATA_W-1:0] tx_wr_data = 0, rx_wr_data = 0;
    logic [DATA_W-1:0] tx_rd_data, rx_rd_data;
    logic tx_rd_tag, tx_irq, rx_irq, tx_dma_req, rx_dma_req, tx_overflow, rx_underflow;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic [BW-1:0] tx_burst_len, rx_burst_len;

    always #10 clk = ~clk;

    svc_fifo_pair #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_svc_fifo_pair (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en),
        .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
        .tx_irq_clr(tx_irq_clr), .rx_irq_clr(rx_irq_clr),
        .tx_dma_ack(tx_dma_ack), .rx_dma_ack(rx_dma_ack),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_tag_ctl(tx_tag_ctl),
        .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data), .tx_rd_tag(tx_rd_tag),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_irq(tx_irq), .rx_irq(rx_irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .tx_burst_len(tx_burst_len), .rx_burst_len(rx_burst_len),
        .tx_overflow(tx_overflow), .rx_underflow(rx_underflow)
    );

    // ---------------- behavioural reference model ----------------
    logic [DATA_W:0]   m_txq[$];
    logic [DATA_W-1:0] m_rxq[$];
    bit m_tirq, m_rirq, m_tdma, m_rdma, m_ovf, m_unf;
    bit tc, rc, t_full, t_emp, r_full, r_emp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_txq.delete(); m_rxq.delete();
            m_tirq = 0; m_rirq = 0; m_tdma = 0; m_rdma = 0; m_ovf = 0; m_unf = 0;
        end else begin
            tc = m_txq.size() < int'(tx_thresh);
            rc = m_rxq.size() > int'(rx_thresh);
            m_tirq = tx_irq_en && (tc || (m_tirq && !tx_irq_clr));
            m_rirq = rx_irq_en && (rc || (m_rirq && !rx_irq_clr));
            m_tdma = tx_dma_en && (m_tdma ? !tx_dma_ack : tc);
            m_rdma = rx_dma_en && (m_rdma ? !rx_dma_ack : rc);
            if (flush) begin
                m_txq.delete(); m_rxq.delete(); m_ovf = 0; m_unf = 0;
            end else begin
                t_full = m_txq.size() == DEPTH; t_emp = m_txq.size() == 0;
                r_full = m_rxq.size() == DEPTH; r_emp = m_rxq.size() == 0;
                if (tx_rd_en && !t_emp) void'(m_txq.pop_front());
                if (tx_wr_en) begin
                    if (t_full) m_ovf = 1;
                    else m_txq.push_back({tx_tag_ctl, tx_wr_data});
                end
                if (rx_rd_en) begin
                    if (r_emp) m_unf = 1;
                    else void'(m_rxq.pop_front());
                end
                if (rx_wr_en && !r_full) m_rxq.push_back(rx_wr_data);
            end
        end
    end

    // ---------------- checking ----------------
    int checks = 0, failures = 0;
    bit done = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [DATA_W:0] th;
        th = (m_txq.size() == 0) ? '0 : m_txq[0];
        chk("R2", "tx_level", 64'(tx_level), 64'(m_txq.size()));
        chk("R2", "tx_rd_data", 64'(tx_rd_data), 64'(th[DATA_W-1:0]));
        chk("R2", "tx_rd_tag", 64'(tx_rd_tag), 64'(th[DATA_W]));
        chk("R3", "tx_overflow", 64'(tx_overflow), 64'(m_ovf));
        chk("R4", "rx_level", 64'(rx_level), 64'(m_rxq.size()));
        chk("R4", "rx_rd_data", 64'(rx_rd_data),
            (m_rxq.size() == 0) ? 64'd0 : 64'(m_rxq[0]));
        chk("R4", "rx_underflow", 64'(rx_underflow), 64'(m_unf));
        chk("R5", "tx_irq", 64'(tx_irq), 64'(m_tirq));
        chk("R6", "rx_irq", 64'(rx_irq), 64'(m_rirq));
        chk("R8", "tx_dma_req", 64'(tx_dma_req), 64'(m_tdma));
        chk("R8", "rx_dma_req", 64'(rx_dma_req), 64'(m_rdma));
        chk("R9", "tx_burst_len", 64'(tx_burst_len), 64'(DEPTH - int'(tx_thresh)));
        chk("R9", "rx_burst_len", 64'(rx_burst_len), 64'(int'(rx_thresh) + 1));
    endtask

    task automatic strobes_off();
        flush = 0; tx_irq_clr = 0; rx_irq_clr = 0; tx_dma_ack = 0; rx_dma_ack = 0;
        tx_wr_en = 0; tx_rd_en = 0; rx_wr_en = 0; rx_rd_en = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        strobes_off();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, before any clock edge out of reset
        chk("R1", "tx_level", 64'(tx_level), 0);
        chk("R1", "rx_level", 64'(rx_level), 0);
        chk("R1", "requests", 64'({tx_irq, rx_irq, tx_dma_req, rx_dma_req}), 0);
        chk("R1", "flags", 64'({tx_overflow, rx_underflow}), 0);

        tick();
        chk("R5", "tx_irq armed on empty queue", 64'(tx_irq), 1);

        for (int i = 0; i < 6; i++) begin
            tx_wr_en = 1; tx_wr_data = 32'hA000 + i; tx_tag_ctl = i[0];
            tick();
        end
        tx_irq_clr = 1; tick();
        chk("R7", "tx_irq after clear with condition false", 64'(tx_irq), 0);
        tx_dma_ack = 1; tick();
        chk("R8", "tx_dma_req after ack", 64'(tx_dma_req), 0);

        for (int i = 0; i < 3; i++) begin
            tx_rd_en = 1; tick();
        end
        chk("R2", "tx_rd_tag of fourth word", 64'(tx_rd_tag), 1);

        for (int i = 0; i < 30; i++) begin
            tx_wr_en = 1; tx_wr_data = 32'hB000 + i; tx_tag_ctl = 1'b1; tick();
        end
        chk("R3", "tx_level at full", 64'(tx_level), DEPTH);
        chk("R3", "tx_overflow set", 64'(tx_overflow), 1);

        for (int i = 0; i < 5; i++) begin
            rx_wr_en = 1; rx_wr_data = 32'hC000 + i; tick();
        end
        tick();
        rx_irq_clr = 1; tick();
        chk("R7", "rx_irq survives clear while level above threshold", 64'(rx_irq), 1);

        for (int i = 0; i < 6; i++) begin
            rx_rd_en = 1; tick();
        end
        chk("R4", "rx_underflow set", 64'(rx_underflow), 1);
        chk("R4", "rx_rd_data when empty", 64'(rx_rd_data), 0);

        rx_wr_en = 1; rx_wr_data = 32'h5; tick();
        flush = 1; tx_wr_en = 1; tx_wr_data = 32'hDEAD; rx_wr_en = 1; tick();
        chk("R10", "tx_level after flush", 64'(tx_level), 0);
        chk("R10", "rx_level after flush", 64'(rx_level), 0);
        chk("R10", "flags after flush", 64'({tx_overflow, rx_underflow}), 0);

        tx_dma_en = 0; tick();
        chk("R11", "tx_dma_req after disable", 64'(tx_dma_req), 0);
        tx_dma_en = 1;

        tx_thresh = 0; rx_thresh = 23; tick();
        chk("R9", "tx_burst_len thresh 0", 64'(tx_burst_len), 24);
        chk("R9", "rx_burst_len thresh 23", 64'(rx_burst_len), 24);
        tx_thresh = 24; rx_thresh = 0; tick();
        chk("R9", "tx_burst_len thresh 24", 64'(tx_burst_len), 0);
        chk("R9", "rx_burst_len thresh 0", 64'(rx_burst_len), 1);

        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 99) == 0) begin
                tx_thresh = LVL_W'($urandom_range(0, DEPTH));
                rx_thresh = LVL_W'($urandom_range(0, DEPTH));
            end
            if ($urandom_range(0, 199) == 0) begin
                {tx_irq_en, rx_irq_en, tx_dma_en, rx_dma_en} = 4'($urandom_range(0, 15));
            end
            tx_wr_en   = $urandom_range(0, 1);
            tx_wr_data = $urandom;
            tx_tag_ctl = $urandom_range(0, 1);
            tx_rd_en   = $urandom_range(0, 2) == 0;
            rx_wr_en   = $urandom_range(0, 2) == 0;
            rx_wr_data = $urandom;
            rx_rd_en   = $urandom_range(0, 1);
            tx_irq_clr = $urandom_range(0, 3) == 0;
            rx_irq_clr = $urandom_range(0, 3) == 0;
            tx_dma_ack = $urandom_range(0, 3) == 0;
            rx_dma_ack = $urandom_range(0, 3) == 0;
            flush      = $urandom_range(0, 63) == 0;
            tick();
        end
        summary();
    end
endmodule